// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a binary up-counter in which every state change happens on the rising clock edge. It has three synchronous controls. An active-low clear zeroes the count. An active-low load copies a data word into the count. Two active-high count enables must both be high for the count to advance. The "parallel" enable is shared by every stage. The "trickle" enable also gates a combinational carry-out. That carry-out is high while the count sits at all ones and the trickle enable is high, so it can drive the trickle enable of the next, more significant stage.

The top level chains `STAGES` slices of `WIDTH` bits into one counter that is `WIDTH*STAGES` bits wide. All slices share the clock, clear, load and parallel enable. Each slice's carry feeds the trickle enable of the slice above it. An optional short-count mode decodes a chosen terminal value from the outputs and folds it into the synchronous clear. The counter then wraps to zero after that value instead of after all ones. With a terminal value of 9 this gives a decade counter. A synchronous active-high reset zeroes the counter ahead of every other control.

Top module: `cascade_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes 0 after that edge, whatever the other controls are.
- R2: When `clr_n` is low at a rising edge (and `rst` is low), `q` becomes 0, regardless of `load_n`, `en_p` and `en_t`.
- R3: When `load_n` is low and `clr_n` is high at a rising edge, `q` takes the value of `data`, regardless of both enables. Any value in range may be loaded.
- R4: When `clr_n`, `load_n`, `en_p` and `en_t` are all high at a rising edge, `q` increases by one in plain binary. From all ones it wraps to 0.
- R5: When `clr_n` and `load_n` are high and either `en_p` or `en_t` is low, `q` keeps its value across the edge.
- R6: `rco` is high in the same cycle exactly when `en_t` is high and `q` is all ones. `en_p` has no effect on it.
- R7: In the chained counter, a slice advances only when every lower slice is at all ones and `en_t` is high. The whole of `q` therefore counts as one binary number of `WIDTH*STAGES` bits, with the least significant slice at bits `WIDTH-1:0`.
- R8: Changing `clr_n`, `load_n`, `en_p` or `en_t` between rising edges leaves `q` unchanged until the next rising edge.
- R9: With `SHORT_EN` set, when `q` equals `TERM_VALUE` and the counter would advance (`clr_n`, `load_n`, `en_p`, `en_t` all high), the next edge gives 0. The count length is therefore `TERM_VALUE+1`. At `TERM_VALUE` with an enable low, the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst | input | 1 | Synchronous active-high reset, highest priority |
| clr_n | input | 1 | Synchronous active-low clear |
| load_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Parallel count enable, shared by all slices |
| en_t | input | 1 | Trickle count enable into the lowest slice; also gates `rco` |
| data | input | WIDTH*STAGES | Value copied into the count on a load |
| q | output | WIDTH*STAGES | Current count |
| rco | output | 1 | Carry-out: `en_t` high and the whole count at all ones |

## Verification
The situation that is hardest to reach from the ports is an upper slice seeing its trickle enable rise. That happens only in the single cycle when the lower slice sits at all ones. Counting up to that point would take many cycles and would mask mistakes in the chaining. The bench therefore loads values just below a slice boundary (0x0F, 0x7F, 0xFE) and then steps one or two counts across it. It also sweeps all sixteen combinations of clear, load and the two enables from a preset of 0x7F, where a single count crosses the boundary. The short-count instance is run through several full cycles. It is also held at its terminal value with an enable low, and loaded above that value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Operation chosen for the next rising edge, in priority order.
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } op_e;

  // Clear beats load, load beats count; counting needs both enables.
  function automatic op_e pick_op(input logic clr_n, input logic load_n,
                                  input logic en_p, input logic en_t);
    op_e op;
    if (!clr_n)             op = OP_CLEAR;
    else if (!load_n)       op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/term_match.sv
module term_match #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] VALUE = '1
) (
  input  logic [WIDTH-1:0] value,
  output logic             hit
);

  assign hit = (value == VALUE);

endmodule

// File: rtl/count_stage.sv
module count_stage
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             rco
);

  logic [WIDTH-1:0] q_r = '0;
  op_e              op;
  logic             at_top;

  always_comb op = pick_op(clr_n, load_n, en_p, en_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      case (op)
        OP_CLEAR: q_r <= '0;
        OP_LOAD:  q_r <= d;
        OP_COUNT: q_r <= q_r + WIDTH'(1);
        default:  q_r <= q_r;
      endcase
    end
  end

  term_match #(.WIDTH(WIDTH), .VALUE('1)) u_top (
    .value (q_r),
    .hit   (at_top)
  );

  assign q   = q_r;
  assign rco = en_t & at_top;

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == '0));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> (q == $past(d)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t) |=> (q == $past(q) + WIDTH'(1)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

  // R6
  rco_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    rco |-> (en_t && (q == '1)));

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int WIDTH      = 4,
  parameter int STAGES     = 2,
  parameter bit SHORT_EN   = 1'b0,
  parameter int TERM_VALUE = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_n,
  input  logic                    load_n,
  input  logic                    en_p,
  input  logic                    en_t,
  input  logic [WIDTH*STAGES-1:0] data,
  output logic [WIDTH*STAGES-1:0] q,
  output logic                    rco
);

  localparam int TOTAL = WIDTH * STAGES;

  logic [STAGES:0] chain;
  logic            term_hit;
  logic            wrap;
  logic            clr_eff;

  assign chain[0] = en_t;

  generate
    if (SHORT_EN) begin : g_short
      term_match #(.WIDTH(TOTAL), .VALUE(TOTAL'(TERM_VALUE))) u_term (
        .value (q),
        .hit   (term_hit)
      );
      assign wrap = term_hit & load_n & en_p & en_t;
    end else begin : g_full
      assign term_hit = 1'b0;
      assign wrap     = 1'b0;
    end
  endgenerate

  assign clr_eff = clr_n & ~wrap;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      count_stage #(.WIDTH(WIDTH)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_eff),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (chain[g]),
        .d      (data[g*WIDTH +: WIDTH]),
        .q      (q[g*WIDTH +: WIDTH]),
        .rco    (chain[g+1])
      );
    end
  endgenerate

  assign rco = chain[STAGES];

  // R7
  full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (rco && en_p && clr_n && load_n) |=> (q == '0));

  // R9
  short_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (term_hit && clr_n && load_n && en_p && en_t) |=> (q == '0));

  // R7
  carry_level_chk: assert property (@(posedge clk) disable iff (rst)
    rco |-> (q == '1));

endmodule

// File: tb/test_cascade_counter.sv
module test_cascade_counter;

  logic       clk = 1'b0;
  logic       rst, clr_n, load_n, en_p, en_t;
  logic [7:0] data;
  logic [7:0] q;
  logic       rco;

  logic       m_rst, m_clr_n, m_load_n, m_en_p, m_en_t;
  logic [3:0] m_data;
  logic [3:0] m_q;
  logic       m_rco;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cascade_counter #(.WIDTH(4), .STAGES(2)) i_cascade_counter (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .data(data), .q(q), .rco(rco)
  );

  cascade_counter #(.WIDTH(4), .STAGES(1), .SHORT_EN(1'b1), .TERM_VALUE(9))
    i_cascade_counter_mod10 (
    .clk(clk), .rst(m_rst), .clr_n(m_clr_n), .load_n(m_load_n),
    .en_p(m_en_p), .en_t(m_en_t), .data(m_data), .q(m_q), .rco(m_rco)
  );

  task automatic check(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One rising edge, then settle away from it.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic ctl(input logic c, input logic l, input logic p, input logic t);
    clr_n = c; load_n = l; en_p = p; en_t = t;
  endtask

  task automatic preset(input logic [7:0] v);
    ctl(1, 0, 0, 0); data = v; step();
  endtask

  task automatic t_reset();
    rst = 1; ctl(1, 0, 1, 1); data = 8'hAB; step();
    check(q, 0, "R1 reset dominates load");
    rst = 0;
  endtask

  task automatic t_clear();
    preset(8'h5A);
    ctl(0, 0, 1, 1); data = 8'h33; step();
    check(q, 0, "R2 clear over load and enables");
  endtask

  task automatic t_load();
    ctl(1, 0, 0, 0); data = 8'hC3; step();
    check(q, 8'hC3, "R3 load with enables low");
    ctl(1, 0, 1, 1); data = 8'h3C; step();
    check(q, 8'h3C, "R3 load with enables high");
  endtask

  task automatic t_count();
    ctl(1, 1, 1, 1);
    for (int i = 1; i <= 3; i++) begin
      step();
      check(q, 8'h3C + i, "R4 increment");
    end
    preset(8'h0F);
    ctl(1, 1, 1, 1); step();
    check(q, 8'h10, "R7 carry into upper slice");
    step();
    check(q, 8'h11, "R7 upper slice holds after carry");
    preset(8'hFE);
    ctl(1, 1, 1, 1); step();
    check(q, 8'hFF, "R4 reach all ones");
    check(rco, 1, "R6 rco at all ones with en_t");
    step();
    check(q, 8'h00, "R4 wrap to zero");
    check(rco, 0, "R6 rco low after wrap");
  endtask

  task automatic t_hold_rco();
    preset(8'hFF);
    ctl(1, 1, 0, 1); step();
    check(q, 8'hFF, "R5 hold with en_p low");
    check(rco, 1, "R6 rco ignores en_p");
    ctl(1, 1, 1, 0); step();
    check(q, 8'hFF, "R5 hold with en_t low");
    check(rco, 0, "R6 rco low with en_t low");
    preset(8'h0F);
    ctl(1, 1, 1, 1); #1;
    check(rco, 0, "R6 rco low with only lower slice at ones");
  endtask

  task automatic t_between();
    preset(8'h20);
    ctl(0, 0, 1, 1); data = 8'h99; #2;
    check(q, 8'h20, "R8 mid-cycle control change ignored");
    ctl(1, 1, 1, 1); step();
    check(q, 8'h21, "R8 next edge uses settled controls");
  endtask

  task automatic t_priority();
    for (int c = 0; c < 16; c++) begin
      int exp;
      preset(8'h7F);
      ctl(c[3], c[2], c[1], c[0]); data = 8'hA5; step();
      if (!c[3])            exp = 0;
      else if (!c[2])       exp = 8'hA5;
      else if (c[1] && c[0]) exp = 8'h80;
      else                  exp = 8'h7F;
      check(q, exp, "R2 R3 R4 R5 priority combination");
    end
  endtask

  task automatic t_mod10();
    m_rst = 1; m_clr_n = 1; m_load_n = 1; m_en_p = 1; m_en_t = 1; m_data = 0;
    step();
    check(m_q, 0, "R1 short counter reset");
    m_rst = 0;
    for (int i = 1; i <= 25; i++) begin
      step();
      check(m_q, i % 10, "R9 decade sequence");
    end
    m_load_n = 0; m_data = 4'd9; step();
    m_load_n = 1; m_en_p = 0; step();
    check(m_q, 9, "R9 hold at terminal with enable low");
    m_en_p = 1; step();
    check(m_q, 0, "R9 wrap from terminal");
    m_load_n = 0; m_data = 4'd13; step();
    m_load_n = 1;
    step(); check(m_q, 14, "R9 above terminal counts on");
    step(); check(m_q, 15, "R9 reaches all ones");
    check(m_rco, 1, "R6 short counter rco");
    step(); check(m_q, 0, "R4 wrap above terminal");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst = 1; ctl(1, 1, 0, 0); data = 0;
    m_rst = 1; m_clr_n = 1; m_load_n = 1; m_en_p = 0; m_en_t = 0; m_data = 0;
    step();
    t_reset();
    t_clear();
    t_load();
    t_count();
    t_hold_rco();
    t_between();
    t_priority();
    t_mod10();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule